// File: doc/BRIEF.md
# Bus-Strobed Memory-Map Address Decoder

This block turns the upper address lines of a 16-bit microprocessor bus, a bus-cycle strobe and a direction line into active-low chip selects for seven peripherals, plus active-low read and write strobes. It is purely combinational. Nothing is selected, and neither strobe is asserted, unless the bus-cycle strobe is high.

Decoding is partial. Only address bits A15..A11 reach the block, so every device answers across a whole aligned 2K or 8K window, and an address such as 0x8001 selects the same device as 0x8000. A device is selected only when both the address window and the transfer direction match its entry in the map. This lets a write-only device and a read-only device share one window.

The decode runs in two levels. The first level is a one-of-eight decoder on A15..A13, gated by the strobe, which picks an 8K region. The second level is a one-of-four decoder on A12..A11, enabled by region 0x8000–0x9FFF, which picks a 2K sub-block. A mapping stage then applies the direction. The block has no state machine and no states.

Top module: `addr_map_decoder`

## Requirements
- R1: `rd_n` is 0 exactly when `bus_e`=1 and `rd_nwr`=1; otherwise it is 1.
- R2: `wr_n` is 0 exactly when `bus_e`=1 and `rd_nwr`=0; otherwise it is 1.
- R3: While `bus_e`=0, every bit of `cs_n` is 1, whatever the address and direction.
- R4: At most one bit of `cs_n` is 0 at any time.
- R5: For addresses 0x8000–0x87FF (`addr_hi`=5'b10000), a write drives `cs_n[0]` (heater) low and a read drives `cs_n[1]` (temperature sensor) low. Any address inside this window, such as 0x8001, selects the same device.
- R6: For addresses 0x8800–0x8FFF (`addr_hi`=5'b10001), a write drives `cs_n[2]` (air conditioner) low. A read selects nothing.
- R7: For addresses 0x9000–0x97FF (`addr_hi`=5'b10010), a write drives `cs_n[3]` (temperature display) low and a read drives `cs_n[4]` (set point) low.
- R8: For addresses 0xC000–0xDFFF (`addr_hi`=5'b110xx), `cs_n[5]` (RAM) is low for both reads and writes.
- R9: For addresses 0xE000–0xFFFF (`addr_hi`=5'b111xx), a read drives `cs_n[6]` (ROM) low. A write selects nothing.
- R10: Addresses 0x0000–0x7FFF and 0x9800–0xBFFF select no device in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_hi | input | 5 | Address bits A15..A11 (bit 4 = A15) |
| bus_e | input | 1 | Bus-cycle strobe, active high |
| rd_nwr | input | 1 | Direction: 1 = read, 0 = write |
| cs_n | output | 7 | Active-low chip selects: 0 heater, 1 sensor, 2 air conditioner, 3 display, 4 set point, 5 RAM, 6 ROM |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Directed vectors cover both directions inside each device window. Read/write pairs in a shared window tell apart the two devices that share it. A read in the air-conditioner window and a write in ROM space show that the direction check blocks a select even when the address matches. Vectors in the 0x9800 gap and in low memory separate a partial decode that is correct from one that leaks into unmapped space. A full sweep over all five address bits, the strobe and the direction is then compared against an independent range-based model. This sweep catches a wrong bit slice, a select that is not gated by the strobe, or a swapped direction.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;
    localparam int NUM_DEV    = 7;
    localparam int DEC_W      = 5;   // A15..A11
    localparam int REGION_W   = 3;   // A15..A13
    localparam int SUB_W      = DEC_W - REGION_W;
    localparam int NUM_REGION = 1 << REGION_W;
    localparam int NUM_SUB    = 1 << SUB_W;

    localparam int DEV_HEATER  = 0;
    localparam int DEV_SENSOR  = 1;
    localparam int DEV_AIRCON  = 2;
    localparam int DEV_DISPLAY = 3;
    localparam int DEV_SETPT   = 4;
    localparam int DEV_RAM     = 5;
    localparam int DEV_ROM     = 6;

    localparam int REG_PERIPH = 4;   // 0x8000-0x9FFF
    localparam int REG_RAM    = 6;   // 0xC000-0xDFFF
    localparam int REG_ROM    = 7;   // 0xE000-0xFFFF
endpackage

// File: rtl/addr_onehot_dec.sv
module addr_onehot_dec #(
    parameter int SEL_W = 3
) (
    input  logic                   en,
    input  logic [SEL_W-1:0]       sel,
    output logic [(1<<SEL_W)-1:0]  hit
);
    localparam int OUT_N = 1 << SEL_W;

    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign hit[g] = en && (sel == SEL_W'(g));
    end
endmodule

// File: rtl/addr_strobe_gen.sv
module addr_strobe_gen (
    input  logic bus_e,
    input  logic rd_nwr,
    output logic rd_n,
    output logic wr_n
);
    always_comb begin
        rd_n = !(bus_e && rd_nwr);
        wr_n = !(bus_e && !rd_nwr);
    end
endmodule

// File: rtl/addr_select_map.sv
module addr_select_map
    import addr_map_pkg::*;
(
    input  logic [NUM_REGION-1:0] region_hit,
    input  logic [NUM_SUB-1:0]    sub_hit,
    input  logic                  is_read,
    output logic [NUM_DEV-1:0]    cs_n
);
    logic [NUM_DEV-1:0] active;

    always_comb begin
        active              = '0;
        active[DEV_HEATER]  = sub_hit[0] && !is_read;
        active[DEV_SENSOR]  = sub_hit[0] &&  is_read;
        active[DEV_AIRCON]  = sub_hit[1] && !is_read;
        active[DEV_DISPLAY] = sub_hit[2] && !is_read;
        active[DEV_SETPT]   = sub_hit[2] &&  is_read;
        active[DEV_RAM]     = region_hit[REG_RAM];
        active[DEV_ROM]     = region_hit[REG_ROM] && is_read;
        cs_n                = ~active;
    end
endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder
    import addr_map_pkg::*;
(
    input  logic [DEC_W-1:0]   addr_hi,
    input  logic               bus_e,
    input  logic               rd_nwr,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               rd_n,
    output logic               wr_n
);
    logic [NUM_REGION-1:0] region_hit;
    logic [NUM_SUB-1:0]    sub_hit;

    addr_onehot_dec #(.SEL_W(REGION_W)) i_region_dec (
        .en  (bus_e),
        .sel (addr_hi[DEC_W-1:SUB_W]),
        .hit (region_hit)
    );

    addr_onehot_dec #(.SEL_W(SUB_W)) i_sub_dec (
        .en  (region_hit[REG_PERIPH]),
        .sel (addr_hi[SUB_W-1:0]),
        .hit (sub_hit)
    );

    addr_select_map i_map (
        .region_hit (region_hit),
        .sub_hit    (sub_hit),
        .is_read    (rd_nwr),
        .cs_n       (cs_n)
    );

    addr_strobe_gen i_strobe (
        .bus_e  (bus_e),
        .rd_nwr (rd_nwr),
        .rd_n   (rd_n),
        .wr_n   (wr_n)
    );
endmodule

// File: rtl/addr_map_decoder_chk.sv
module addr_map_decoder_chk
    import addr_map_pkg::*;
(
    input logic [DEC_W-1:0]   addr_hi,
    input logic               bus_e,
    input logic               rd_nwr,
    input logic [NUM_DEV-1:0] cs_n,
    input logic               rd_n,
    input logic               wr_n
);
    always_comb begin
        if (!$isunknown({addr_hi, bus_e, rd_nwr, cs_n, rd_n, wr_n})) begin
            if (!rd_n) AST_RD_NEEDS_READ: assert (bus_e && rd_nwr);      // R1
            if (!wr_n) AST_WR_NEEDS_WRITE: assert (bus_e && !rd_nwr);    // R2
            if (!bus_e) AST_CS_IDLE: assert (&cs_n);                     // R3
            AST_ONE_CS: assert ($countones(~cs_n) <= 1);                 // R4
            if (!cs_n[DEV_AIRCON]) AST_AIRCON_WRITE: assert (!wr_n);     // R6
            if (!cs_n[DEV_ROM]) AST_ROM_READ: assert (!rd_n);            // R9
            if (!addr_hi[DEC_W-1]) AST_LOW_UNMAPPED: assert (&cs_n);     // R10
        end
    end
endmodule

bind addr_map_decoder addr_map_decoder_chk i_chk (
    .addr_hi (addr_hi),
    .bus_e   (bus_e),
    .rd_nwr  (rd_nwr),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n)
);

// File: tb/test_addr_map_decoder.sv
module test_addr_map_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr_hi = '0;
    logic       bus_e = 1'b0;
    logic       rd_nwr = 1'b0;
    logic [6:0] cs_n;
    logic       rd_n, wr_n;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    addr_map_decoder i_addr_map_decoder (
        .addr_hi (addr_hi),
        .bus_e   (bus_e),
        .rd_nwr  (rd_nwr),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n)
    );

    // {req[3:0], addr_hi[4:0], bus_e, rd_nwr, exp_cs_n[6:0]}
    localparam int NV = 13;
    localparam logic [17:0] VEC [NV] = '{
        {4'd5,  5'b10000, 1'b1, 1'b0, 7'b1111110},  // R5 heater write
        {4'd5,  5'b10000, 1'b1, 1'b1, 7'b1111101},  // R5 sensor read
        {4'd6,  5'b10001, 1'b1, 1'b0, 7'b1111011},  // R6 aircon write
        {4'd6,  5'b10001, 1'b1, 1'b1, 7'b1111111},  // R6 read: none
        {4'd7,  5'b10010, 1'b1, 1'b0, 7'b1110111},  // R7 display write
        {4'd7,  5'b10010, 1'b1, 1'b1, 7'b1101111},  // R7 set point read
        {4'd8,  5'b11000, 1'b1, 1'b0, 7'b1011111},  // R8 RAM write
        {4'd8,  5'b11011, 1'b1, 1'b1, 7'b1011111},  // R8 RAM read
        {4'd9,  5'b11100, 1'b1, 1'b1, 7'b0111111},  // R9 ROM read
        {4'd9,  5'b11111, 1'b1, 1'b0, 7'b1111111},  // R9 ROM write: none
        {4'd10, 5'b10011, 1'b1, 1'b1, 7'b1111111},  // R10 0x9800 gap
        {4'd10, 5'b00000, 1'b1, 1'b0, 7'b1111111},  // R10 low memory
        {4'd3,  5'b10000, 1'b0, 1'b0, 7'b1111111}   // R3 strobe low
    };

    function automatic logic [6:0] model_cs(input logic [4:0] a, input logic e, input logic rd);
        logic [15:0] ad;
        logic [6:0]  act;
        ad  = {a, 11'h000};
        act = '0;
        if (e) begin
            if (ad >= 16'h8000 && ad <= 16'h87FF) act[rd ? 1 : 0] = 1'b1;
            else if (ad >= 16'h8800 && ad <= 16'h8FFF) act[2] = !rd;
            else if (ad >= 16'h9000 && ad <= 16'h97FF) act[rd ? 4 : 3] = 1'b1;
            else if (ad >= 16'hC000 && ad <= 16'hDFFF) act[5] = 1'b1;
            else if (ad >= 16'hE000) act[6] = rd;
        end
        return ~act;
    endfunction

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [4:0] a, input logic e, input logic rd);
        @(negedge clk);
        addr_hi = a; bus_e = e; rd_nwr = rd;
        #1;
    endtask

    initial begin
        // reset state: strobe idle
        repeat (3) @(posedge clk);
        rst = 1'b0;
        apply(5'b10000, 1'b0, 1'b1);
        check("R3 reset cs_n", cs_n, 7'h7F);
        check("R1 reset rd_n", {6'b0, rd_n}, 7'd1);
        check("R2 reset wr_n", {6'b0, wr_n}, 7'd1);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][13:9], VEC[i][8], VEC[i][7]);
            check($sformatf("R%0d vector %0d", VEC[i][17:14], i), cs_n, VEC[i][6:0]);
        end

        // R5 partial decode: any low-order bits within the window are ignored
        apply(5'b10000, 1'b1, 1'b0);
        check("R5 0x8001 heater", cs_n, 7'b1111110);

        // full sweep against the range model
        for (int v = 0; v < 128; v++) begin
            logic [6:0] exp;
            apply(v[4:0], v[5], v[6]);
            exp = model_cs(v[4:0], v[5], v[6]);
            check($sformatf("R4 sweep %0d cs_n", v), cs_n, exp);
            check($sformatf("R1 sweep %0d rd_n", v), {6'b0, rd_n}, {6'b0, !(v[5] && v[6])});
            check($sformatf("R2 sweep %0d wr_n", v), {6'b0, wr_n}, {6'b0, !(v[5] && !v[6])});
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule